// File: doc/BRIEF.md
# Phase Modulation Loader and Phase Adder

This block sits between a 32-bit phase accumulator and a sine lookup stage. It takes a 12-bit modulation word and adds it to the top 13 bits of the accumulator. The result is a registered 13-bit modulated phase, suitable as a lookup address. The upper 12 bits of the modulation word carry the weight of the 12 upper phase bits, so the word's most significant bit shifts the phase by half a turn.

The modulation word comes from one of two sources, chosen by `src_sel`. With `src_sel` high, the word comes from a 12-bit buffer that the bus fills in two writes. The buffer changes only when a write strobe rises while chip select is active. With `src_sel` low, the word is read straight off the pins: the eight data lines form the high part and the four address lines form the low part. This direct path ignores chip select and the write strobe, which allows fast parallel modulation.

A falling edge on `mod_load` transfers the selected word. Eleven clocks after the load, a one-clock low pulse on `mod_sync_n` marks the point where the change takes effect downstream. A second register, clocked by its own `cap_clk`, holds a snapshot of the upper 12 bits of the modulated phase.

Top module: `pm_phase_adder`

## Requirements
- R1: While reset is low, and after it is released, the modulation word is zero, `mod_phase` is 0, `mod_sync_n` is 1 and `cap_phase` is 0. After release with no load, `mod_phase` equals the top 13 accumulator bits.
- R2: Buffer low-nibble write. With `src_sel`=1 and `cs_n`=0, a rising edge of `wr_strobe` with `bus_addr`=1x00 writes `bus_data[7:4]` into buffer bits 3:0.
- R3: Buffer high-byte write. With `src_sel`=1 and `cs_n`=0, a rising edge of `wr_strobe` with `bus_addr`=1x01 writes `bus_data[7:0]` into buffer bits 11:4.
- R4: Buffer writes are ignored when `cs_n`=1, or when the address is 0xxx or 1x1x.
- R5: With `src_sel`=0, the loaded word is {`bus_data`, `bus_addr`}: data supplies bits 11:4 and address supplies bits 3:0. `cs_n` and `wr_strobe` have no effect on it.
- R6: Load timing. A falling edge of `mod_load` is seen at clock edge 1. The source word is sampled at edge 2. `mod_phase` shows the new word after edge 3. After edge 2 it still shows the old word.
- R7: Phase sum. After each clock edge, `mod_phase` = (acc_phase[31:19] + {word, 1'b0}) mod 8192, using the acc_phase sampled at that edge. Bit 0 of `mod_phase` equals acc_phase[19].
- R8: Sync pulse. `mod_sync_n` is normally 1. It goes to 0 for exactly one cycle after edge 11, counting the edge that sees the load's falling edge as edge 1.
- R9: On each rising edge of `cap_clk`, `cap_phase` takes `mod_phase[12:1]`. Between those edges it holds its value.
- R10: Buffer writes do not change `mod_phase` until a later load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_phase | input | 32 | Phase accumulator value |
| bus_data | input | 8 | Bus data; high word bits in direct mode |
| bus_addr | input | 4 | Bus address; low word bits in direct mode |
| cs_n | input | 1 | Active-low chip select for buffer writes |
| wr_strobe | input | 1 | Buffer write strobe, acts on its rising edge |
| src_sel | input | 1 | 1: buffer source, 0: direct pins |
| mod_load | input | 1 | Load strobe, acts on its falling edge |
| cap_clk | input | 1 | Clock for the phase snapshot register |
| mod_phase | output | 13 | Registered modulated phase |
| mod_sync_n | output | 1 | Active-low one-clock sync pulse |
| cap_phase | output | 12 | Snapshot of mod_phase[12:1] |

## Verification
The bench checks wraparound of the 13-bit sum at full-scale words and at an all-ones accumulator top. A design that kept a carry bit, or that aligned the word one bit too low, would give the wrong output value in those cases.

It checks the output one cycle before the load takes effect as well as on the cycle it does. It also checks that the sync pulse lands exactly after edge 11. These checks catch a pipeline that is one register short or one register long.

For the buffer, the bench writes with chip select inactive and at unused addresses, and confirms that these writes are ignored. It also confirms that a valid write does not reach the output without a load.

Finally, it holds the snapshot clock still while the phase changes, to confirm that the snapshot register does not track the main clock.

// File: rtl/pm_pkg.sv
package pm_pkg;
  // kinds of bus write accepted by the modulation buffer
  typedef enum logic [1:0] {
    WR_NONE = 2'd0,
    WR_LOW  = 2'd1,
    WR_HIGH = 2'd2
  } wr_kind_t;
endpackage

// File: rtl/pm_rst_sync.sv
module pm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pm_mod_word.sv
module pm_mod_word
  import pm_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 4,
  localparam int MOD_W = BYTE_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] bus_data,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              cs_n,
  input  logic              wr_strobe,
  input  logic              src_sel,
  input  logic              mod_load,
  output logic [MOD_W-1:0]  mod_word,
  output logic              load_pulse
);
  logic             wr_prev_q, ld_prev_q, load_q;
  logic [MOD_W-1:0] buf_q, word_q;
  logic [MOD_W-1:0] buf_d, word_d;
  logic             load_d;
  wr_kind_t         wr_kind;
  logic             buf_en, word_en;

  // write decode: rising strobe, chip selected, buffer source, address 1x0x
  always_comb begin
    wr_kind = WR_NONE;
    if (wr_strobe && !wr_prev_q && !cs_n && src_sel &&
        bus_addr[ADDR_W-1] && !bus_addr[1]) begin
      wr_kind = bus_addr[0] ? WR_HIGH : WR_LOW;
    end
  end

  always_comb begin
    buf_en = (wr_kind != WR_NONE);
    buf_d  = buf_q;
    case (wr_kind)
      WR_LOW:  buf_d[ADDR_W-1:0]     = bus_data[BYTE_W-1 -: ADDR_W];
      WR_HIGH: buf_d[MOD_W-1:ADDR_W] = bus_data;
      default: buf_d = buf_q;
    endcase
  end

  always_comb begin
    load_d  = ld_prev_q & ~mod_load;
    word_en = load_q;
    word_d  = src_sel ? buf_q : {bus_data, bus_addr};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_prev_q <= 1'b0;
      ld_prev_q <= 1'b0;
      load_q    <= 1'b0;
    end else begin
      wr_prev_q <= wr_strobe;
      ld_prev_q <= mod_load;
      load_q    <= load_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      buf_q <= '0;
    else if (buf_en) buf_q <= buf_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (word_en) word_q <= word_d;
  end

  assign mod_word   = word_q;
  assign load_pulse = load_q;
endmodule

// File: rtl/pm_sync_pipe.sv
module pm_sync_pipe #(
  parameter int LAT = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic sync_n
);
  // start already carries one register of latency
  localparam int STG = LAT - 1;
  logic [STG-1:0] stg_q;
  logic [STG-1:0] stg_d;

  generate
    if (STG == 1) begin : g_one
      always_comb stg_d = start;
    end else begin : g_many
      always_comb stg_d = {stg_q[STG-2:0], start};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign sync_n = ~stg_q[STG-1];
endmodule

// File: rtl/pm_phase_sum.sv
module pm_phase_sum #(
  parameter int LUT_W = 13,
  parameter int MOD_W = 12,
  localparam int PAD = LUT_W - MOD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LUT_W-1:0] acc_top,
  input  logic [MOD_W-1:0] mod_word,
  output logic [LUT_W-1:0] sum_q
);
  logic [LUT_W-1:0] sum_d;

  always_comb begin
    sum_d = acc_top + {mod_word, {PAD{1'b0}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sum_q <= '0;
    else        sum_q <= sum_d;
  end
endmodule

// File: rtl/pm_phase_adder.sv
module pm_phase_adder #(
  parameter int ACC_W    = 32,
  parameter int LUT_W    = 13,
  parameter int BYTE_W   = 8,
  parameter int ADDR_W   = 4,
  parameter int SYNC_LAT = 11
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ACC_W-1:0]          acc_phase,
  input  logic [BYTE_W-1:0]         bus_data,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic                      cs_n,
  input  logic                      wr_strobe,
  input  logic                      src_sel,
  input  logic                      mod_load,
  input  logic                      cap_clk,
  output logic [LUT_W-1:0]          mod_phase,
  output logic                      mod_sync_n,
  output logic [BYTE_W+ADDR_W-1:0]  cap_phase
);
  localparam int MOD_W = BYTE_W + ADDR_W;
  localparam int LOW_W = ACC_W - LUT_W;

  logic             rst_core_n, rst_cap_n;
  logic [MOD_W-1:0] mod_word;
  logic             load_pulse;
  logic [MOD_W-1:0] cap_d, cap_q;
  logic             unused_low;

  assign unused_low = ^acc_phase[LOW_W-1:0];

  pm_rst_sync #(.STAGES(2)) u_rst_core (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_core_n));

  pm_rst_sync #(.STAGES(2)) u_rst_cap (
    .clk(cap_clk), .rst_n(rst_n), .rst_sync_n(rst_cap_n));

  pm_mod_word #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_word (
    .clk(clk), .rst_n(rst_core_n), .bus_data(bus_data), .bus_addr(bus_addr),
    .cs_n(cs_n), .wr_strobe(wr_strobe), .src_sel(src_sel),
    .mod_load(mod_load), .mod_word(mod_word), .load_pulse(load_pulse));

  pm_phase_sum #(.LUT_W(LUT_W), .MOD_W(MOD_W)) u_sum (
    .clk(clk), .rst_n(rst_core_n), .acc_top(acc_phase[ACC_W-1 -: LUT_W]),
    .mod_word(mod_word), .sum_q(mod_phase));

  pm_sync_pipe #(.LAT(SYNC_LAT)) u_sync (
    .clk(clk), .rst_n(rst_core_n), .start(load_pulse), .sync_n(mod_sync_n));

  // snapshot of the upper modulated phase bits on the separate clock
  always_comb begin
    cap_d = mod_phase[LUT_W-1 -: MOD_W];
  end

  always_ff @(posedge cap_clk or negedge rst_cap_n) begin
    if (!rst_cap_n) cap_q <= '0;
    else            cap_q <= cap_d;
  end

  assign cap_phase = cap_q;
endmodule

// File: rtl/pm_phase_adder_chk.sv
module pm_phase_adder_chk #(
  parameter int LUT_W    = 13,
  parameter int MOD_W    = 12,
  parameter int SYNC_LAT = 11
) (
  input logic             clk,
  input logic             rst_s,
  input logic             acc_lsb,
  input logic             mod_load,
  input logic [LUT_W-1:0] mod_phase,
  input logic             mod_sync_n,
  input logic [MOD_W-1:0] mod_word,
  input logic             load_pulse
);
  localparam int CW = $clog2(SYNC_LAT + 1) + 1;
  logic          ld_prev;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      ld_prev <= 1'b0;
      cnt     <= '0;
    end else begin
      ld_prev <= mod_load;
      if (ld_prev && !mod_load)               cnt <= CW'(1);
      else if (cnt == CW'(SYNC_LAT))          cnt <= '0;
      else if (cnt != '0)                     cnt <= cnt + CW'(1);
    end
  end

  // R8: the sync pulse lasts one cycle
  p_sync_single_r8: assert property (@(posedge clk) disable iff (!rst_s)
    !mod_sync_n |=> mod_sync_n);

  // R8: the sync pulse appears only at the counted latency
  p_sync_latency_r8: assert property (@(posedge clk) disable iff (!rst_s)
    !mod_sync_n |-> cnt == CW'(SYNC_LAT));

  // R7: bit 0 of the phase follows the accumulator bit below the word
  p_bit0_pass_r7: assert property (@(posedge clk) disable iff (!rst_s)
    $past(rst_s) |-> mod_phase[0] == $past(acc_lsb));

  // R10: the active word changes only after a load pulse
  p_word_hold_r10: assert property (@(posedge clk) disable iff (!rst_s)
    $past(rst_s) && !$past(load_pulse) |-> $stable(mod_word));
endmodule

bind pm_phase_adder pm_phase_adder_chk #(
  .LUT_W(LUT_W), .MOD_W(BYTE_W + ADDR_W), .SYNC_LAT(SYNC_LAT)
) u_chk (
  .clk(clk), .rst_s(rst_core_n), .acc_lsb(acc_phase[ACC_W-LUT_W]),
  .mod_load(mod_load), .mod_phase(mod_phase), .mod_sync_n(mod_sync_n),
  .mod_word(mod_word), .load_pulse(load_pulse));

// File: tb/pm_phase_adder_test.sv
module pm_phase_adder_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [12:0] top;
    logic [7:0]  d;
    logic [3:0]  a;
    logic [12:0] exp;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{13'h0000, 8'h00, 4'h0, 13'h0000},
    '{13'h0001, 8'h00, 4'h1, 13'h0003},
    '{13'h1000, 8'h80, 4'h0, 13'h0000},
    '{13'h1FFF, 8'h00, 4'h1, 13'h0001},
    '{13'h0ABC, 8'h12, 4'h3, 13'h0D02},
    '{13'h1555, 8'hFF, 4'hF, 13'h1553}
  };

  logic        clk = 1'b0;
  logic        rst_n, cs_n, wr_strobe, src_sel, mod_load, cap_clk;
  logic [31:0] acc_phase;
  logic [7:0]  bus_data;
  logic [3:0]  bus_addr;
  logic [12:0] mod_phase;
  logic        mod_sync_n;
  logic [11:0] cap_phase;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [11:0] cur_word;

  always #(CLK_PERIOD/2) clk = ~clk;

  pm_phase_adder uut (
    .clk(clk), .rst_n(rst_n), .acc_phase(acc_phase), .bus_data(bus_data),
    .bus_addr(bus_addr), .cs_n(cs_n), .wr_strobe(wr_strobe),
    .src_sel(src_sel), .mod_load(mod_load), .cap_clk(cap_clk),
    .mod_phase(mod_phase), .mod_sync_n(mod_sync_n), .cap_phase(cap_phase));

  function automatic logic [12:0] model(input logic [12:0] top,
                                        input logic [11:0] w);
    return top + {w, 1'b0};
  endfunction

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_top(input logic [12:0] t);
    acc_phase = {t, 19'h0};
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d,
                           input logic cs);
    bus_addr = a; bus_data = d; cs_n = cs;
    step(1);
    wr_strobe = 1'b1;
    step(1);
    wr_strobe = 1'b0;
    cs_n = 1'b1;
    step(1);
  endtask

  task automatic cap_pulse();
    #1 cap_clk = 1'b1;
    #1 cap_clk = 1'b0;
  endtask

  // drives a load, checks R6 timing, the sum, and R8 sync position
  task automatic do_load(input logic [12:0] top, input logic [11:0] w,
                         input string req);
    int lows = 0;
    int low_at = 0;
    mod_load = 1'b1;
    step(1);
    mod_load = 1'b0;
    for (int e = 1; e <= 13; e++) begin
      step(1);
      if (e == 2) chk(mod_phase == model(top, cur_word), "R6 old word",
                      mod_phase, model(top, cur_word));
      if (e == 3) chk(mod_phase == model(top, w), req, mod_phase,
                      model(top, w));
      if (!mod_sync_n) begin lows++; low_at = e; end
    end
    chk(lows == 1 && low_at == 11, "R8 sync edge", low_at, 11);
    cur_word = w;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; wr_strobe = 1'b0; src_sel = 1'b0;
    mod_load = 1'b0; cap_clk = 1'b0; acc_phase = '0;
    bus_data = '0; bus_addr = '0; cur_word = '0;
    step(3);
    chk(mod_phase == 13'h0 && mod_sync_n && cap_phase == 12'h0,
        "R1 reset state", {mod_phase, mod_sync_n, cap_phase}, 32'h1000);
    rst_n = 1'b1;
    step(4);
    repeat (3) cap_pulse();
    step(1);
    chk(mod_phase == 13'h0, "R1 after release", mod_phase, 0);

    // direct source table; cs_n held high, strobe idle (R5, R7)
    src_sel = 1'b0;
    foreach (VECS[i]) begin
      set_top(VECS[i].top);
      bus_data = VECS[i].d;
      bus_addr = VECS[i].a;
      chk(model(VECS[i].top, {VECS[i].d, VECS[i].a}) == VECS[i].exp,
          "R7 table", model(VECS[i].top, {VECS[i].d, VECS[i].a}), VECS[i].exp);
      do_load(VECS[i].top, {VECS[i].d, VECS[i].a}, "R5 R7 direct word");
      chk(mod_phase[0] == VECS[i].top[0], "R7 bit0", mod_phase[0],
          VECS[i].top[0]);
    end

    // buffer writes (R2, R3) invisible until load (R10)
    src_sel = 1'b1;
    set_top(13'h0001);
    bus_write(4'b1101, 8'hA5, 1'b0);
    bus_write(4'b1100, 8'h3C, 1'b0);
    step(1);
    chk(mod_phase == model(13'h0001, cur_word), "R10 no load yet",
        mod_phase, model(13'h0001, cur_word));
    do_load(13'h0001, 12'hA53, "R2 R3 buffer word");
    chk(mod_phase == 13'h14A7, "R2 R3 value", mod_phase, 13'h14A7);

    // ignored writes (R4)
    bus_write(4'b1101, 8'h00, 1'b1);
    bus_write(4'b1010, 8'h00, 1'b0);
    bus_write(4'b0001, 8'h00, 1'b0);
    bus_write(4'b0100, 8'h00, 1'b0);
    do_load(13'h0001, 12'hA53, "R4 ignored writes");

    // low nibble only rewrite (R2)
    bus_write(4'b1000, 8'h70, 1'b0);
    do_load(13'h0001, 12'hA57, "R2 nibble rewrite");

    // snapshot register (R9)
    cap_pulse();
    step(1);
    chk(cap_phase == 12'hA57, "R9 capture", cap_phase, 12'hA57);
    src_sel = 1'b0; bus_data = 8'h00; bus_addr = 4'h0;
    do_load(13'h0001, 12'h000, "R6 zero word");
    chk(cap_phase == 12'hA57, "R9 hold", cap_phase, 12'hA57);
    cap_pulse();
    step(1);
    chk(cap_phase == 12'h000, "R9 recapture", cap_phase, 12'h000);

    // mid-run reset (R1)
    bus_data = 8'h40;
    do_load(13'h0001, 12'h400, "R5 preload");
    rst_n = 1'b0;
    #1;
    chk(mod_phase == 13'h0 && mod_sync_n, "R1 async clear", mod_phase, 0);
    step(2);
    rst_n = 1'b1;
    step(4);
    set_top(13'h0123);
    step(1);
    chk(mod_phase == 13'h0123, "R1 word cleared", mod_phase, 13'h0123);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule